// File: doc/BRIEF.md
# MSI Directory Controller

This block is the home node of an invalidation-based MSI coherence scheme. It tracks a small set of cache lines that up to `N_CACHES` private caches share. For each line it holds a state (stable or transient), a bitmask of sharers, an owner identifier with its own valid bit, a flag marking its copy as newer than memory, and a data copy. Caches send GetS, GetM, PutS and PutM requests on a request channel. Owners return data on a separate response channel. The block answers on three output channels: forwarded requests, invalidations and put acknowledgements on one, data replies with an acknowledgement count on a second, and read and write commands to memory on a third.

Each cycle the block handles at most one event. A memory reply comes first, then a cache response, then a request. A request whose line is in a transient state waits at the head of the request channel, while replies for other lines keep flowing. All outputs are registered. Each output is valid for one cycle, starting in the cycle after the event that caused it.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every line is invalid: no sharers, no owner, `err` low, no output valid and `req_ready` high. At all times a modified line has an owner and no sharers, a shared line has sharers and no owner, and an invalid line has neither.
- R2: A GetS (`req_type`=0) or GetM (`req_type`=1) to an invalid line issues a memory read (`mem_req_write`=0) in the next cycle and sends no data. When memory replies with read data (`mem_rsp_kind`=0), the block sends data to the requestor with an acknowledgement count of 0 in the next cycle. That data is the memory data, and the line becomes shared for a GetS or modified for a GetM.
- R3: A GetM to a shared line sends the directory data to the requestor. The acknowledgement count equals the number of sharers other than the requestor. In the same cycle the block sends one invalidation (`fwd_kind`=2) whose `fwd_mask` holds exactly those sharers and whose `fwd_req` is the requestor. When the requestor was the only sharer, no invalidation is sent.
- R4: A request to a modified line is forwarded to the owner. `fwd_mask` is one-hot on the owner, `fwd_req` is the requestor, and the directory sends no data. A GetS uses `fwd_kind`=0: the old owner joins the sharers, and the data the owner returns on the response channel becomes the directory copy. A GetM uses `fwd_kind`=1, and the requestor becomes the new owner.
- R5: A PutM from the owner writes its data into the line and issues a memory write with that data. The put acknowledgement (`fwd_kind`=3, one-hot mask on the putter) is sent only in the cycle after memory reports the write done (`mem_rsp_kind`=1). The line then becomes invalid.
- R6: A PutS or PutM from a cache that neither owns nor shares the line is answered with a put acknowledgement and leaves the line unchanged, with no memory traffic.
- R7: A PutS, or a PutM from a sharer of a shared line, removes that cache from the sharers and is acknowledged at once. The line becomes invalid only when the last sharer puts it, so a later GetS then causes a fresh memory read.
- R8: When the last sharer puts a line whose directory copy came from an owner and was never written back, the block first writes that copy to memory. It acknowledges the put only after memory reports the write done.
- R9: `req_ready` is low while the addressed line is transient, and also in any cycle with a memory reply or a cache response present. Such a request is held without effect until accepted.
- R10: A memory reply or cache response that the line's state does not expect sets `err`, and `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_type | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_src | input | log2(N_CACHES) | Requesting cache |
| req_line | input | log2(N_LINES) | Line index |
| req_data | input | DATA_W | Dirty data carried by PutM |
| rsp_valid | input | 1 | Owner data response present |
| rsp_line | input | log2(N_LINES) | Line of the response |
| rsp_data | input | DATA_W | Data returned by the old owner |
| mem_rsp_valid | input | 1 | Memory reply present |
| mem_rsp_kind | input | 1 | 0 read data, 1 write done |
| mem_rsp_line | input | log2(N_LINES) | Line of the memory reply |
| mem_rsp_data | input | DATA_W | Read data |
| fwd_valid | output | 1 | Forward, invalidation or put acknowledgement valid |
| fwd_kind | output | 2 | 0 forwarded GetS, 1 forwarded GetM, 2 invalidate, 3 put acknowledgement |
| fwd_mask | output | N_CACHES | Destination caches |
| fwd_req | output | log2(N_CACHES) | Requestor the receivers answer |
| fwd_line | output | log2(N_LINES) | Line index |
| dat_valid | output | 1 | Data reply valid |
| dat_dest | output | log2(N_CACHES) | Receiving cache |
| dat_acks | output | log2(N_CACHES+1) | Invalidation acknowledgements to expect |
| dat_data | output | DATA_W | Line data |
| dat_line | output | log2(N_LINES) | Line index |
| mem_req_valid | output | 1 | Memory command valid |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_line | output | log2(N_LINES) | Line index |
| mem_req_data | output | DATA_W | Write data |
| err | output | 1 | Sticky unexpected-reply flag |

## Verification
A wrong sharer mask shows up one cycle after the next GetM, either as a wrong acknowledgement count or as a wrong invalidation mask. Sweeping every sharer subset against every requestor exposes it on the first pattern it touches. A wrong owner field appears in the destination mask of the next forward. A lost directory copy appears as stale data in the next reply served from the directory. A wrongly invalidated line issues a memory read where a direct data reply was expected. An early acknowledgement shows as `fwd_valid` in the cycle after a put, before memory has reported the write done.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

  typedef enum logic [2:0] {
    ST_I    = 3'd0,
    ST_S    = 3'd1,
    ST_M    = 3'd2,
    ST_IS_D = 3'd3,
    ST_IM_D = 3'd4,
    ST_MS_D = 3'd5,
    ST_MI_A = 3'd6
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_GETS = 2'd0,
    RQ_GETM = 2'd1,
    RQ_PUTS = 2'd2,
    RQ_PUTM = 2'd3
  } req_e;

  typedef enum logic [1:0] {
    FW_GETS   = 2'd0,
    FW_GETM   = 2'd1,
    FW_INV    = 2'd2,
    FW_PUTACK = 2'd3
  } fwd_e;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_REQ  = 2'd1,
    EV_RSP  = 2'd2,
    EV_MEM  = 2'd3
  } ev_e;

  localparam logic MEM_RD_DATA = 1'b0;
  localparam logic MEM_WR_DONE = 1'b1;

  function automatic logic is_stable(input logic [2:0] st);
    return (st == ST_I) || (st == ST_S) || (st == ST_M);
  endfunction

endpackage

// File: rtl/msi_dir_store.sv
module msi_dir_store
  import msi_dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 4,
  parameter int DATA_W   = 32,
  localparam int IDW = $clog2(N_CACHES),
  localparam int LW  = $clog2(N_LINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [LW-1:0]            line,
  input  logic [2:0]               w_state,
  input  logic [N_CACHES-1:0]      w_sh,
  input  logic [IDW-1:0]           w_own,
  input  logic                     w_ov,
  input  logic [IDW-1:0]           w_pend,
  input  logic                     w_dirty,
  input  logic [DATA_W-1:0]        w_data,
  output logic [2:0]               r_state,
  output logic [N_CACHES-1:0]      r_sh,
  output logic [IDW-1:0]           r_own,
  output logic                     r_ov,
  output logic [IDW-1:0]           r_pend,
  output logic                     r_dirty,
  output logic [DATA_W-1:0]        r_data,
  output logic [N_LINES*3-1:0]     st_flat,
  output logic [N_LINES*N_CACHES-1:0] sh_flat,
  output logic [N_LINES-1:0]       ov_flat,
  output logic [N_LINES-1:0]       stable_vec
);

  logic [N_LINES*IDW-1:0]    own_flat;
  logic [N_LINES*IDW-1:0]    pend_flat;
  logic [N_LINES-1:0]        dirty_flat;
  logic [N_LINES*DATA_W-1:0] data_flat;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [2:0]          st_q;
    logic [N_CACHES-1:0] sh_q;
    logic [IDW-1:0]      own_q;
    logic                ov_q;
    logic [IDW-1:0]      pend_q;
    logic                dirty_q;
    logic [DATA_W-1:0]   data_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q    <= ST_I;
        sh_q    <= '0;
        own_q   <= '0;
        ov_q    <= 1'b0;
        pend_q  <= '0;
        dirty_q <= 1'b0;
        data_q  <= '0;
      end else if (we && (line == LW'(g))) begin
        st_q    <= w_state;
        sh_q    <= w_sh;
        own_q   <= w_own;
        ov_q    <= w_ov;
        pend_q  <= w_pend;
        dirty_q <= w_dirty;
        data_q  <= w_data;
      end
    end

    assign st_flat[g*3 +: 3]              = st_q;
    assign sh_flat[g*N_CACHES +: N_CACHES] = sh_q;
    assign own_flat[g*IDW +: IDW]         = own_q;
    assign ov_flat[g]                     = ov_q;
    assign pend_flat[g*IDW +: IDW]        = pend_q;
    assign dirty_flat[g]                  = dirty_q;
    assign data_flat[g*DATA_W +: DATA_W]  = data_q;
    assign stable_vec[g]                  = is_stable(st_q);
  end

  assign r_state = st_flat[line*3 +: 3];
  assign r_sh    = sh_flat[line*N_CACHES +: N_CACHES];
  assign r_own   = own_flat[line*IDW +: IDW];
  assign r_ov    = ov_flat[line];
  assign r_pend  = pend_flat[line*IDW +: IDW];
  assign r_dirty = dirty_flat[line];
  assign r_data  = data_flat[line*DATA_W +: DATA_W];

endmodule

// File: rtl/msi_dir_arb.sv
module msi_dir_arb
  import msi_dir_pkg::*;
#(
  parameter int N_LINES = 4,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               req_valid,
  input  logic [LW-1:0]      req_line,
  input  logic               rsp_valid,
  input  logic [LW-1:0]      rsp_line,
  input  logic               mem_rsp_valid,
  input  logic [LW-1:0]      mem_rsp_line,
  input  logic [N_LINES-1:0] stable_vec,
  output ev_e                ev,
  output logic [LW-1:0]      sel_line,
  output logic               req_ready
);

  logic reply_busy;
  assign reply_busy = mem_rsp_valid || rsp_valid;
  assign req_ready  = !reply_busy && stable_vec[req_line];

  always_comb begin
    ev       = EV_NONE;
    sel_line = req_line;
    if (mem_rsp_valid) begin
      ev       = EV_MEM;
      sel_line = mem_rsp_line;
    end else if (rsp_valid) begin
      ev       = EV_RSP;
      sel_line = rsp_line;
    end else if (req_valid && req_ready) begin
      ev = EV_REQ;
    end
  end

endmodule

// File: rtl/msi_dir_xition.sv
module msi_dir_xition
  import msi_dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int DATA_W   = 32,
  localparam int IDW = $clog2(N_CACHES),
  localparam int CW  = $clog2(N_CACHES+1)
) (
  input  ev_e                  ev,
  input  logic [1:0]           rq_type,
  input  logic [IDW-1:0]       rq_src,
  input  logic [DATA_W-1:0]    rq_data,
  input  logic [DATA_W-1:0]    rsp_data,
  input  logic                 mem_kind,
  input  logic [DATA_W-1:0]    mem_data,
  input  logic [2:0]           c_state,
  input  logic [N_CACHES-1:0]  c_sh,
  input  logic [IDW-1:0]       c_own,
  input  logic                 c_ov,
  input  logic [IDW-1:0]       c_pend,
  input  logic                 c_dirty,
  input  logic [DATA_W-1:0]    c_data,
  output logic                 upd,
  output logic [2:0]           n_state,
  output logic [N_CACHES-1:0]  n_sh,
  output logic [IDW-1:0]       n_own,
  output logic                 n_ov,
  output logic [IDW-1:0]       n_pend,
  output logic                 n_dirty,
  output logic [DATA_W-1:0]    n_data,
  output logic                 o_fwd_v,
  output logic [1:0]           o_fwd_kind,
  output logic [N_CACHES-1:0]  o_fwd_mask,
  output logic [IDW-1:0]       o_fwd_req,
  output logic                 o_dat_v,
  output logic [IDW-1:0]       o_dat_dest,
  output logic [CW-1:0]        o_dat_acks,
  output logic [DATA_W-1:0]    o_dat_data,
  output logic                 o_mem_v,
  output logic                 o_mem_wr,
  output logic [DATA_W-1:0]    o_mem_data,
  output logic                 o_err
);

  function automatic logic [N_CACHES-1:0] bit_of(input logic [IDW-1:0] id);
    logic [N_CACHES-1:0] m;
    m = '0;
    m[id] = 1'b1;
    return m;
  endfunction

  function automatic logic [CW-1:0] count_set(input logic [N_CACHES-1:0] m);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < N_CACHES; i++) c = c + CW'(m[i]);
    return c;
  endfunction

  dstate_e             cs;
  req_e                rq;
  logic [N_CACHES-1:0] src_bit;
  logic [N_CACHES-1:0] rest;

  assign cs      = dstate_e'(c_state);
  assign rq      = req_e'(rq_type);
  assign src_bit = bit_of(rq_src);
  assign rest    = c_sh & ~src_bit;

  always_comb begin
    upd = 1'b0;
    n_state = c_state; n_sh = c_sh; n_own = c_own; n_ov = c_ov;
    n_pend = c_pend; n_dirty = c_dirty; n_data = c_data;
    o_fwd_v = 1'b0; o_fwd_kind = FW_GETS; o_fwd_mask = '0; o_fwd_req = '0;
    o_dat_v = 1'b0; o_dat_dest = '0; o_dat_acks = '0; o_dat_data = '0;
    o_mem_v = 1'b0; o_mem_wr = 1'b0; o_mem_data = '0;
    o_err = 1'b0;
    unique case (ev)
      EV_REQ: begin
        upd = 1'b1;
        unique case (cs)
          ST_I: begin
            if (rq == RQ_GETS || rq == RQ_GETM) begin
              n_state = (rq == RQ_GETS) ? ST_IS_D : ST_IM_D;
              n_pend  = rq_src;
              o_mem_v = 1'b1;
            end else begin
              o_fwd_v = 1'b1; o_fwd_kind = FW_PUTACK;
              o_fwd_mask = src_bit; o_fwd_req = rq_src;
            end
          end
          ST_S: begin
            if (rq == RQ_GETS) begin
              n_sh = c_sh | src_bit;
              o_dat_v = 1'b1; o_dat_dest = rq_src; o_dat_data = c_data;
            end else if (rq == RQ_GETM) begin
              o_dat_v = 1'b1; o_dat_dest = rq_src; o_dat_data = c_data;
              o_dat_acks = count_set(rest);
              if (rest != '0) begin
                o_fwd_v = 1'b1; o_fwd_kind = FW_INV;
                o_fwd_mask = rest; o_fwd_req = rq_src;
              end
              n_state = ST_M; n_sh = '0; n_own = rq_src; n_ov = 1'b1;
            end else begin
              n_sh = rest;
              if (rest == '0 && c_dirty) begin
                n_state = ST_MI_A; n_pend = rq_src;
                o_mem_v = 1'b1; o_mem_wr = 1'b1; o_mem_data = c_data;
              end else begin
                if (rest == '0) n_state = ST_I;
                o_fwd_v = 1'b1; o_fwd_kind = FW_PUTACK;
                o_fwd_mask = src_bit; o_fwd_req = rq_src;
              end
            end
          end
          ST_M: begin
            if ((rq == RQ_GETS || rq == RQ_GETM) && c_own == rq_src) begin
              o_err = 1'b1;
            end else if (rq == RQ_GETS) begin
              o_fwd_v = 1'b1; o_fwd_kind = FW_GETS;
              o_fwd_mask = bit_of(c_own); o_fwd_req = rq_src;
              n_state = ST_MS_D; n_sh = bit_of(c_own) | src_bit; n_ov = 1'b0;
            end else if (rq == RQ_GETM) begin
              o_fwd_v = 1'b1; o_fwd_kind = FW_GETM;
              o_fwd_mask = bit_of(c_own); o_fwd_req = rq_src;
              n_own = rq_src;
            end else if (rq == RQ_PUTM && c_own == rq_src) begin
              n_data = rq_data; n_ov = 1'b0; n_state = ST_MI_A; n_pend = rq_src;
              o_mem_v = 1'b1; o_mem_wr = 1'b1; o_mem_data = rq_data;
            end else begin
              o_fwd_v = 1'b1; o_fwd_kind = FW_PUTACK;
              o_fwd_mask = src_bit; o_fwd_req = rq_src;
            end
          end
          default: begin
            upd = 1'b0;
            o_err = 1'b1;
          end
        endcase
      end
      EV_RSP: begin
        if (cs == ST_MS_D) begin
          upd = 1'b1; n_data = rsp_data; n_dirty = 1'b1; n_state = ST_S;
        end else begin
          o_err = 1'b1;
        end
      end
      EV_MEM: begin
        if ((cs == ST_IS_D || cs == ST_IM_D) && mem_kind == MEM_RD_DATA) begin
          upd = 1'b1; n_data = mem_data; n_dirty = 1'b0;
          o_dat_v = 1'b1; o_dat_dest = c_pend; o_dat_data = mem_data;
          if (cs == ST_IS_D) begin
            n_state = ST_S; n_sh = bit_of(c_pend);
          end else begin
            n_state = ST_M; n_own = c_pend; n_ov = 1'b1;
          end
        end else if (cs == ST_MI_A && mem_kind == MEM_WR_DONE) begin
          upd = 1'b1; n_state = ST_I; n_dirty = 1'b0; n_sh = '0;
          o_fwd_v = 1'b1; o_fwd_kind = FW_PUTACK;
          o_fwd_mask = bit_of(c_pend); o_fwd_req = c_pend;
        end else begin
          o_err = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
  import msi_dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 4,
  parameter int DATA_W   = 32,
  localparam int IDW = $clog2(N_CACHES),
  localparam int LW  = $clog2(N_LINES),
  localparam int CW  = $clog2(N_CACHES+1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_type,
  input  logic [IDW-1:0]      req_src,
  input  logic [LW-1:0]       req_line,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                rsp_valid,
  input  logic [LW-1:0]       rsp_line,
  input  logic [DATA_W-1:0]   rsp_data,
  input  logic                mem_rsp_valid,
  input  logic                mem_rsp_kind,
  input  logic [LW-1:0]       mem_rsp_line,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  output logic                fwd_valid,
  output logic [1:0]          fwd_kind,
  output logic [N_CACHES-1:0] fwd_mask,
  output logic [IDW-1:0]      fwd_req,
  output logic [LW-1:0]       fwd_line,
  output logic                dat_valid,
  output logic [IDW-1:0]      dat_dest,
  output logic [CW-1:0]       dat_acks,
  output logic [DATA_W-1:0]   dat_data,
  output logic [LW-1:0]       dat_line,
  output logic                mem_req_valid,
  output logic                mem_req_write,
  output logic [LW-1:0]       mem_req_line,
  output logic [DATA_W-1:0]   mem_req_data,
  output logic                err
);

  ev_e                        ev;
  logic [LW-1:0]              sel_line;
  logic [N_LINES-1:0]         stable_vec;
  logic [N_LINES*3-1:0]       st_flat;
  logic [N_LINES*N_CACHES-1:0] sh_flat;
  logic [N_LINES-1:0]         ov_flat;
  logic                       ev_req_fire;

  logic [2:0]          sel_state;
  logic [N_CACHES-1:0] c_sh;
  logic [IDW-1:0]      c_own, c_pend;
  logic                c_ov, c_dirty;
  logic [DATA_W-1:0]   c_data;

  logic                upd;
  logic [2:0]          n_state;
  logic [N_CACHES-1:0] n_sh;
  logic [IDW-1:0]      n_own, n_pend;
  logic                n_ov, n_dirty;
  logic [DATA_W-1:0]   n_data;

  logic                x_fwd_v, x_dat_v, x_mem_v, x_mem_wr, x_err;
  logic [1:0]          x_fwd_kind;
  logic [N_CACHES-1:0] x_fwd_mask;
  logic [IDW-1:0]      x_fwd_req, x_dat_dest;
  logic [CW-1:0]       x_dat_acks;
  logic [DATA_W-1:0]   x_dat_data, x_mem_data;

  assign ev_req_fire = (ev == EV_REQ);

  msi_dir_arb #(.N_LINES(N_LINES)) arb_i (
    .req_valid(req_valid), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_line(rsp_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
    .stable_vec(stable_vec), .ev(ev), .sel_line(sel_line), .req_ready(req_ready)
  );

  msi_dir_store #(.N_CACHES(N_CACHES), .N_LINES(N_LINES), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .we(upd), .line(sel_line),
    .w_state(n_state), .w_sh(n_sh), .w_own(n_own), .w_ov(n_ov),
    .w_pend(n_pend), .w_dirty(n_dirty), .w_data(n_data),
    .r_state(sel_state), .r_sh(c_sh), .r_own(c_own), .r_ov(c_ov),
    .r_pend(c_pend), .r_dirty(c_dirty), .r_data(c_data),
    .st_flat(st_flat), .sh_flat(sh_flat), .ov_flat(ov_flat), .stable_vec(stable_vec)
  );

  msi_dir_xition #(.N_CACHES(N_CACHES), .DATA_W(DATA_W)) xition_i (
    .ev(ev), .rq_type(req_type), .rq_src(req_src), .rq_data(req_data),
    .rsp_data(rsp_data), .mem_kind(mem_rsp_kind), .mem_data(mem_rsp_data),
    .c_state(sel_state), .c_sh(c_sh), .c_own(c_own), .c_ov(c_ov),
    .c_pend(c_pend), .c_dirty(c_dirty), .c_data(c_data),
    .upd(upd), .n_state(n_state), .n_sh(n_sh), .n_own(n_own), .n_ov(n_ov),
    .n_pend(n_pend), .n_dirty(n_dirty), .n_data(n_data),
    .o_fwd_v(x_fwd_v), .o_fwd_kind(x_fwd_kind), .o_fwd_mask(x_fwd_mask),
    .o_fwd_req(x_fwd_req), .o_dat_v(x_dat_v), .o_dat_dest(x_dat_dest),
    .o_dat_acks(x_dat_acks), .o_dat_data(x_dat_data), .o_mem_v(x_mem_v),
    .o_mem_wr(x_mem_wr), .o_mem_data(x_mem_data), .o_err(x_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0; fwd_kind <= '0; fwd_mask <= '0; fwd_req <= '0; fwd_line <= '0;
      dat_valid <= 1'b0; dat_dest <= '0; dat_acks <= '0; dat_data <= '0; dat_line <= '0;
      mem_req_valid <= 1'b0; mem_req_write <= 1'b0; mem_req_line <= '0; mem_req_data <= '0;
      err <= 1'b0;
    end else begin
      fwd_valid <= x_fwd_v; fwd_kind <= x_fwd_kind; fwd_mask <= x_fwd_mask;
      fwd_req <= x_fwd_req; fwd_line <= sel_line;
      dat_valid <= x_dat_v; dat_dest <= x_dat_dest; dat_acks <= x_dat_acks;
      dat_data <= x_dat_data; dat_line <= sel_line;
      mem_req_valid <= x_mem_v; mem_req_write <= x_mem_wr;
      mem_req_line <= sel_line; mem_req_data <= x_mem_data;
      err <= err | x_err;
    end
  end

endmodule

// File: rtl/msi_dir_chk.sv
module msi_dir_chk
  import msi_dir_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 4,
  localparam int IDW = $clog2(N_CACHES),
  localparam int CW  = $clog2(N_CACHES+1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_LINES*3-1:0]        st_flat,
  input logic [N_LINES*N_CACHES-1:0] sh_flat,
  input logic [N_LINES-1:0]          ov_flat,
  input logic [1:0]                  req_type,
  input logic                        req_ready,
  input logic                        rsp_valid,
  input logic                        mem_rsp_valid,
  input logic                        mem_rsp_kind,
  input logic                        fwd_valid,
  input logic [1:0]                  fwd_kind,
  input logic [N_CACHES-1:0]         fwd_mask,
  input logic [IDW-1:0]              fwd_req,
  input logic                        dat_valid,
  input logic [CW-1:0]               dat_acks,
  input logic                        mem_req_valid,
  input logic                        mem_req_write,
  input logic                        err,
  input logic                        ev_req_fire,
  input logic [2:0]                  sel_state
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_inv
    AST_MOD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flat[g*3 +: 3] == ST_M) |-> (sh_flat[g*N_CACHES +: N_CACHES] == '0 && ov_flat[g])); // R1
    AST_SHR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flat[g*3 +: 3] == ST_S) |-> (sh_flat[g*N_CACHES +: N_CACHES] != '0 && !ov_flat[g])); // R1
    AST_INV_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flat[g*3 +: 3] == ST_I) |-> (sh_flat[g*N_CACHES +: N_CACHES] == '0 && !ov_flat[g])); // R1
  end

  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req_fire && sel_state == ST_I && !req_type[1]) |=> (mem_req_valid && !mem_req_write && !dat_valid)); // R2

  AST_INV_MATCHES_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_kind == FW_INV) |-> (dat_valid && dat_acks == CW'($countones(fwd_mask)) && !fwd_mask[fwd_req])); // R3

  AST_FWD_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_kind != FW_INV) |-> ($countones(fwd_mask) == 1)); // R4

  AST_ACK_AFTER_WDONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_kind && sel_state == ST_MI_A) |=> (fwd_valid && fwd_kind == FW_PUTACK)); // R5

  AST_REPLY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rsp_valid) |-> !req_ready); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10

endmodule

bind msi_dir_ctrl msi_dir_chk #(.N_CACHES(N_CACHES), .N_LINES(N_LINES)) chk_i (.*);

// File: tb/msi_dir_ctrl_tb.sv
module msi_dir_ctrl_tb_top;

  localparam int N = 4;
  localparam int L = 4;
  localparam int DW = 16;
  localparam logic [1:0] GS = 2'd0, GM = 2'd1, PS = 2'd2, PM = 2'd3;
  localparam logic [1:0] FGS = 2'd0, FGM = 2'd1, FINV = 2'd2, FACK = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_type = '0;
  logic [1:0] req_src = '0;
  logic [1:0] req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_valid = 1'b0;
  logic [1:0] rsp_line = '0;
  logic [DW-1:0] rsp_data = '0;
  logic mem_rsp_valid = 1'b0, mem_rsp_kind = 1'b0;
  logic [1:0] mem_rsp_line = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic fwd_valid; logic [1:0] fwd_kind; logic [N-1:0] fwd_mask; logic [1:0] fwd_req, fwd_line;
  logic dat_valid; logic [1:0] dat_dest; logic [2:0] dat_acks; logic [DW-1:0] dat_data; logic [1:0] dat_line;
  logic mem_req_valid, mem_req_write; logic [1:0] mem_req_line; logic [DW-1:0] mem_req_data;
  logic err;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [DW-1:0] mem_m [L];

  always #4 clk = ~clk;

  msi_dir_ctrl #(.N_CACHES(N), .N_LINES(L), .DATA_W(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0; mem_rsp_valid = 1'b0;
  endtask

  task automatic send_req(input logic [1:0] t, input int s, input int l, input logic [DW-1:0] d);
    req_valid = 1'b1; req_type = t; req_src = 2'(s); req_line = 2'(l); req_data = d;
    #1;
    chk(req_ready == 1'b1, "R9 accept", 32'(req_ready), 32'd1);
    tick();
  endtask

  task automatic send_rsp(input int l, input logic [DW-1:0] d);
    rsp_valid = 1'b1; rsp_line = 2'(l); rsp_data = d;
    tick();
  endtask

  task automatic send_mem(input logic k, input int l, input logic [DW-1:0] d);
    mem_rsp_valid = 1'b1; mem_rsp_kind = k; mem_rsp_line = 2'(l); mem_rsp_data = d;
    tick();
  endtask

  task automatic try_stall(input string tag, input logic [1:0] t, input int s, input int l);
    req_valid = 1'b1; req_type = t; req_src = 2'(s); req_line = 2'(l);
    #1;
    chk(req_ready == 1'b0, tag, 32'(req_ready), 32'd0);
    req_valid = 1'b0;
  endtask

  task automatic exp_data(input string tag, input int d, input int a, input logic [DW-1:0] v, input int l);
    logic [31:0] act, exp;
    act = 32'({dat_valid, dat_dest, dat_acks, dat_line, dat_data});
    exp = 32'({1'b1, 2'(d), 3'(a), 2'(l), v});
    chk(act == exp, tag, act, exp);
  endtask

  task automatic exp_nodata(input string tag);
    chk(dat_valid == 1'b0, tag, 32'(dat_valid), 32'd0);
  endtask

  task automatic exp_fwd(input string tag, input logic [1:0] k, input logic [N-1:0] m, input int r, input int l);
    logic [31:0] act, exp;
    act = 32'({fwd_valid, fwd_kind, fwd_mask, fwd_req, fwd_line});
    exp = 32'({1'b1, k, m, 2'(r), 2'(l)});
    chk(act == exp, tag, act, exp);
  endtask

  task automatic exp_nofwd(input string tag);
    chk(fwd_valid == 1'b0, tag, 32'(fwd_valid), 32'd0);
  endtask

  task automatic exp_mem(input string tag, input logic w, input int l, input logic [DW-1:0] v);
    logic [31:0] act, exp;
    act = 32'({mem_req_valid, mem_req_write, mem_req_line, (w ? mem_req_data : 16'h0)});
    exp = 32'({1'b1, w, 2'(l), (w ? v : 16'h0)});
    chk(act == exp, tag, act, exp);
  endtask

  task automatic exp_nomem(input string tag);
    chk(mem_req_valid == 1'b0, tag, 32'(mem_req_valid), 32'd0);
  endtask

  function automatic int ones(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] others;
    logic [DW-1:0] w;
    bit first;
    for (int i = 0; i < L; i++) mem_m[i] = 16'hA000 + 16'(i * 16'h0111);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(err == 1'b0, "R1 err", 32'(err), 32'd0);
    chk({fwd_valid, dat_valid, mem_req_valid} == 3'b000, "R1 outputs idle",
        32'({fwd_valid, dat_valid, mem_req_valid}), 32'd0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    @(negedge clk);

    // Sweep every sharer subset against every GetM requestor on line 0 (R2, R3, R5)
    for (int sub = 1; sub < 16; sub++) begin
      for (int r = 0; r < N; r++) begin
        first = 1;
        for (int c = 0; c < N; c++) begin
          if (sub[c]) begin
            send_req(GS, c, 0, '0);
            if (first) begin
              exp_mem("R2 fill read", 1'b0, 0, '0);
              exp_nodata("R2 no data before fill");
              send_mem(1'b0, 0, mem_m[0]);
              exp_data("R2 fill data", c, 0, mem_m[0], 0);
              first = 0;
            end else begin
              exp_data("R2 shared read", c, 0, mem_m[0], 0);
              exp_nomem("R2 no memory on hit");
            end
          end
        end
        others = 4'(sub) & ~(4'b1 << r);
        send_req(GM, r, 0, '0);
        exp_data("R3 upgrade acks", r, ones(others), mem_m[0], 0);
        if (others != '0) exp_fwd("R3 invalidation", FINV, others, r, 0);
        else exp_nofwd("R3 no invalidation");
        w = 16'h5000 + 16'(sub * 4 + r);
        send_req(PM, r, 0, w);
        exp_mem("R5 writeback", 1'b1, 0, w);
        exp_nofwd("R5 ack waits for memory");
        mem_m[0] = w;
        send_mem(1'b1, 0, '0);
        exp_fwd("R5 ack after write done", FACK, 4'b1 << r, r, 0);
      end
    end

    // Modified-line forwarding on line 1 (R4, R6, R7, R8)
    send_req(GM, 0, 1, '0);
    exp_mem("R2 fill for GetM", 1'b0, 1, '0);
    send_mem(1'b0, 1, mem_m[1]);
    exp_data("R2 GetM fill data", 0, 0, mem_m[1], 1);
    send_req(GS, 1, 1, '0);
    exp_fwd("R4 forward GetS", FGS, 4'b0001, 1, 1);
    exp_nodata("R4 no directory data");
    try_stall("R9 transient stall", GS, 2, 1);
    send_rsp(1, 16'hBEEF);
    exp_nodata("R4 response silent");
    exp_nofwd("R4 response silent fwd");
    send_req(GS, 2, 1, '0);
    exp_data("R4 owner data kept", 2, 0, 16'hBEEF, 1);
    send_req(GM, 3, 1, '0);
    exp_fwd("R4 old owner shares", FINV, 4'b0111, 3, 1);
    exp_data("R4 acks after forward", 3, 3, 16'hBEEF, 1);
    send_req(GM, 0, 1, '0);
    exp_fwd("R4 forward GetM", FGM, 4'b1000, 0, 1);
    exp_nodata("R4 GetM no data");
    send_req(PM, 3, 1, 16'hDEAD);
    exp_fwd("R6 non-owner PutM acked", FACK, 4'b1000, 3, 1);
    exp_nomem("R6 non-owner no memory");
    send_req(GS, 2, 1, '0);
    exp_fwd("R6 owner unchanged", FGS, 4'b0001, 2, 1);
    send_rsp(1, 16'h7777);
    send_req(PM, 0, 1, 16'h1111);
    exp_fwd("R7 PutM from sharer", FACK, 4'b0001, 0, 1);
    exp_nomem("R7 sharer PutM no memory");
    send_req(PS, 2, 1, '0);
    exp_mem("R8 dirty last put writes", 1'b1, 1, 16'h7777);
    exp_nofwd("R8 ack held");
    mem_m[1] = 16'h7777;
    send_mem(1'b1, 1, '0);
    exp_fwd("R8 ack after write done", FACK, 4'b0100, 2, 1);
    send_req(GS, 3, 1, '0);
    exp_mem("R8 line invalid after put", 1'b0, 1, '0);
    send_mem(1'b0, 1, mem_m[1]);
    exp_data("R8 memory holds owner data", 3, 0, 16'h7777, 1);

    // Shared-line puts on line 2 (R6, R7)
    send_req(GS, 0, 2, '0);
    send_mem(1'b0, 2, mem_m[2]);
    send_req(GS, 1, 2, '0);
    send_req(PS, 0, 2, '0);
    exp_fwd("R7 PutS ack", FACK, 4'b0001, 0, 2);
    exp_nomem("R7 clean put no memory");
    send_req(GS, 3, 2, '0);
    exp_data("R7 still shared", 3, 0, mem_m[2], 2);
    exp_nomem("R7 still shared no fill");
    send_req(PS, 1, 2, '0);
    exp_fwd("R7 PutS ack two", FACK, 4'b0010, 1, 2);
    send_req(PS, 3, 2, '0);
    exp_fwd("R7 last clean put ack", FACK, 4'b1000, 3, 2);
    exp_nomem("R7 last clean no write");
    send_req(PS, 1, 3, '0);
    exp_fwd("R6 put to invalid acked", FACK, 4'b0010, 1, 3);
    send_req(GS, 2, 2, '0);
    exp_mem("R7 invalid after last put", 1'b0, 2, '0);

    // Reply beats a waiting request (R9)
    mem_rsp_valid = 1'b1; mem_rsp_kind = 1'b0; mem_rsp_line = 2'd2; mem_rsp_data = mem_m[2];
    req_valid = 1'b1; req_type = GS; req_src = 2'd1; req_line = 2'd3;
    #1;
    chk(req_ready == 1'b0, "R9 reply priority", 32'(req_ready), 32'd0);
    tick();
    exp_data("R9 reply served", 2, 0, mem_m[2], 2);
    exp_nomem("R9 held request no effect");
    send_req(GS, 1, 3, '0);
    exp_mem("R9 held request later fills", 1'b0, 3, '0);
    send_mem(1'b0, 3, mem_m[3]);
    exp_data("R9 later fill data", 1, 0, mem_m[3], 3);

    // Unexpected reply (R10)
    chk(err == 1'b0, "R10 no false error", 32'(err), 32'd0);
    send_mem(1'b1, 2, '0);
    chk(err == 1'b1, "R10 error raised", 32'(err), 32'd1);
    tick();
    tick();
    chk(err == 1'b1, "R10 error sticky", 32'(err), 32'd1);

    finish_run();
  end

endmodule